// File: doc/BRIEF.md
# Single-Address-Field Microprogram Sequencer

This block is the next-address logic of a microprogrammed control unit. It keeps a control-memory address register, which selects one word of a small built-in, read-only control store, and a microprogram counter, which always holds the next sequential address. Every microinstruction word carries a control field, which goes straight out of the block to the datapath, and a single address field. A two-bit select field picks the next address. It can be the counter value, the address field, the address field only when a chosen status condition is true, or an entry address formed from the machine opcode.

After reset the sequencer sits at address 0, where the fetch routine lives, and it waits for a start pulse. From then on it moves one microinstruction per clock. The fetch routine ends in an opcode dispatch. Each machine instruction owns four consecutive words, and its routine returns to address 0.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is 1 at a rising edge, the address register becomes 0, the counter becomes 1 and the sequencer returns to idle. After that edge `curAddr` reads 0 and `ctrlField` shows the control field of word 0.
- R2: While idle, an edge with `start` at 0 leaves `curAddr` unchanged, whatever `opcode` and `condFlags` carry.
- R3: Word bits are {control[7:0], condSel[1:0], nextSel[1:0], addrField[5:0]}, listed from the top bit down. Word a has control = {~a[1:0], a[5:0]}. Word 0 has nextSel 00. Word 1 has nextSel 11. Every other word is typed by a[1:0], with these meanings:
  - a[1:0] = 00 or 10: nextSel 00.
  - a[1:0] = 01: nextSel 10, condSel = a[3:2], addrField 0.
  - a[1:0] = 11: nextSel 01, addrField 0.
  - Unused address fields hold ~a.
  - `ctrlField` is the control field of the word at `curAddr`, read combinationally.
- R4: On an advancing edge (running, or `start` = 1), nextSel 00 loads the counter value into the address register and increments the counter.
- R5: nextSel 01 loads the address field into the address register.
- R6: nextSel 10 loads the address field when the selected condition is 1 and acts as nextSel 00 otherwise. condSel 0 selects a constant 1, and condSel k (k = 1..3) selects `condFlags[k-1]`.
- R7: nextSel 11 loads {opcode, 2'b00} into the address register.
- R8: Whenever the address field or the mapped opcode address is loaded, the counter is loaded with that address plus 1, so sequential flow continues from the new location.
- R9: `opcode` affects the next address only on a nextSel 11 word.
- R10: Once running, the sequencer stays running until reset. `start` then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins sequencing from idle |
| opcode | input | 4 | Opcode from the instruction register |
| condFlags | input | 3 | Status condition inputs |
| ctrlField | output | 8 | Control field of the current microinstruction |
| curAddr | output | 6 | Current control-memory address |

## Verification
The assertions assume that `rst` is asserted at the first edge, so that the registers have known values. They also assume that `opcode` and `condFlags` are stable across each sampling edge. The bench drives all inputs on the falling edge and pulses reset at the start of the run. It then holds `rst` low except for rare random pulses, and each pulse starts a fresh idle period. Random opcodes, flag patterns and start pulses reach every word type. They also reach the condition select that is always true, and start pulses that arrive while the sequencer is already running.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int NS_W = 2;
  localparam int CS_W = 2;

  localparam logic [NS_W-1:0] NS_SEQ  = 2'd0;
  localparam logic [NS_W-1:0] NS_JUMP = 2'd1;
  localparam logic [NS_W-1:0] NS_COND = 2'd2;
  localparam logic [NS_W-1:0] NS_MAP  = 2'd3;

  typedef struct packed {
    logic advance;
    logic loadSeq;
    logic loadAddr;
    logic loadMap;
  } useq_strobe_t;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CTRL_W = 8,
  localparam int WORD_W = CTRL_W + CS_W + NS_W + ADDR_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdWord
);

  function automatic logic [WORD_W-1:0] buildWord(input int idx);
    logic [ADDR_W-1:0] ad;
    logic [CTRL_W-1:0] ctl;
    logic [CS_W-1:0]   cs;
    logic [NS_W-1:0]   ns;
    logic [ADDR_W-1:0] af;
    ad  = ADDR_W'(idx);
    ctl = CTRL_W'({~ad[1:0], ad});
    cs  = '0;
    ns  = NS_SEQ;
    af  = ~ad;
    if (idx == 0) begin
      ns = NS_SEQ;
    end else if (idx == 1) begin
      ns = NS_MAP;
    end else begin
      case (ad[1:0])
        2'd1: begin
          ns = NS_COND;
          cs = ad[3:2];
          af = '0;
        end
        2'd3: begin
          ns = NS_JUMP;
          af = '0;
        end
        default: ns = NS_SEQ;
      endcase
    end
    return {ctl, cs, ns, af};
  endfunction

  logic [WORD_W-1:0] store [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    assign store[gi] = buildWord(gi);
  end

  assign rdWord = store[rdAddr];

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int NCOND = 4
) (
  input  logic               running,
  input  logic               start,
  input  logic [NS_W-1:0]    nextSel,
  input  logic [CS_W-1:0]    condSel,
  input  logic [NCOND-2:0]   condFlags,
  output useq_strobe_t       strobe
);

  logic [NCOND-1:0] condVec;
  logic             condHit;
  logic             advance;
  logic             takeAddr;
  logic             takeMap;

  assign condVec  = {condFlags, 1'b1};
  assign condHit  = condVec[condSel];
  assign advance  = running | start;
  assign takeAddr = (nextSel == NS_JUMP) || ((nextSel == NS_COND) && condHit);
  assign takeMap  = (nextSel == NS_MAP);

  always_comb begin
    strobe          = '0;
    strobe.advance  = advance;
    strobe.loadAddr = advance & takeAddr;
    strobe.loadMap  = advance & takeMap;
    strobe.loadSeq  = advance & ~takeAddr & ~takeMap;
  end

endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int SLOT_W = 2,
  localparam int ADDR_W = OP_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  useq_strobe_t      strobe,
  input  logic [OP_W-1:0]   opcode,
  input  logic [ADDR_W-1:0] addrField,
  output logic [ADDR_W-1:0] carQ,
  output logic              running
);

  logic [ADDR_W-1:0] upcQ;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] loadTarget;

  assign mapAddr    = {opcode, {SLOT_W{1'b0}}};
  assign loadTarget = strobe.loadMap ? mapAddr : addrField;

  always_ff @(posedge clk) begin
    if (rst) begin
      carQ    <= '0;
      upcQ    <= ADDR_W'(1);
      running <= 1'b0;
    end else if (strobe.advance) begin
      running <= 1'b1;
      if (strobe.loadSeq) begin
        carQ <= upcQ;
        upcQ <= upcQ + ADDR_W'(1);
      end else begin
        carQ <= loadTarget;
        upcQ <= loadTarget + ADDR_W'(1);
      end
    end
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int SLOT_W = 2,
  parameter int CTRL_W = 8,
  parameter int NCOND  = 4,
  localparam int ADDR_W = OP_W + SLOT_W,
  localparam int WORD_W = CTRL_W + CS_W + NS_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [NCOND-2:0]  condFlags,
  output logic [CTRL_W-1:0] ctrlField,
  output logic [ADDR_W-1:0] curAddr
);

  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] addrField;
  logic [NS_W-1:0]   nextSel;
  logic [CS_W-1:0]   condSel;
  logic              running;
  useq_strobe_t      strobe;

  assign addrField = word[ADDR_W-1:0];
  assign nextSel   = word[ADDR_W +: NS_W];
  assign condSel   = word[ADDR_W+NS_W +: CS_W];
  assign ctrlField = word[WORD_W-1 -: CTRL_W];

  useq_rom #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) rom_i (
    .rdAddr(curAddr),
    .rdWord(word)
  );

  useq_ctrl #(.NCOND(NCOND)) ctrl_i (
    .running  (running),
    .start    (start),
    .nextSel  (nextSel),
    .condSel  (condSel),
    .condFlags(condFlags),
    .strobe   (strobe)
  );

  useq_datapath #(.OP_W(OP_W), .SLOT_W(SLOT_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opcode   (opcode),
    .addrField(addrField),
    .carQ     (curAddr),
    .running  (running)
  );

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int OP_W   = 4,
  parameter int SLOT_W = 2,
  localparam int ADDR_W = OP_W + SLOT_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [OP_W-1:0]   opcode,
  input logic              running,
  input logic [ADDR_W-1:0] curAddr,
  input logic [ADDR_W-1:0] addrField,
  input logic [1:0]        nextSel,
  input logic [1:0]        condSel
);

  logic adv;
  assign adv = running | start;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (curAddr == '0) && !running);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!running && !start) |=> $stable(curAddr));

  a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
    (adv && nextSel == 2'd0) |=> curAddr == $past(curAddr) + ADDR_W'(1));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    (adv && nextSel == 2'd1) |=> curAddr == $past(addrField));

  a_r6_const_true: assert property (@(posedge clk) disable iff (rst)
    (adv && nextSel == 2'd2 && condSel == 2'd0) |=> curAddr == $past(addrField));

  a_r7_map_entry: assert property (@(posedge clk) disable iff (rst)
    (adv && nextSel == 2'd3) |=> curAddr == {$past(opcode), {SLOT_W{1'b0}}});

  a_r10_stay_running: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

endmodule

bind useq_sequencer useq_sequencer_chk #(.OP_W(OP_W), .SLOT_W(SLOT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .opcode   (opcode),
  .running  (running),
  .curAddr  (curAddr),
  .addrField(addrField),
  .nextSel  (nextSel),
  .condSel  (condSel)
);

// File: tb/useq_sequencer_tb_top.sv
`timescale 1ns/1ps
module useq_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] opcode = '0;
  logic [2:0] condFlags = '0;
  logic [7:0] ctrlField;
  logic [5:0] curAddr;

  int checks = 0;
  int errors = 0;
  int mCar = 0;
  int mUpc = 1;
  bit mRun = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  useq_sequencer dut_i (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .condFlags(condFlags), .ctrlField(ctrlField), .curAddr(curAddr)
  );

  function automatic logic [7:0] expCtrl(input int a);
    logic [5:0] ad;
    ad = 6'(a);
    return {~ad[1:0], ad};
  endfunction

  function automatic int nsOf(input int a);
    if (a == 0) return 0;
    if (a == 1) return 3;
    case (a % 4)
      1: return 2;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Computes the model's next state for the inputs now on the pins; returns a tag.
  task automatic modelStep(output string tag);
    int ns;
    int cs;
    bit hit;
    if (rst) begin
      mCar = 0; mUpc = 1; mRun = 1'b0; tag = "R1";
    end else if (!mRun && !start) begin
      tag = "R2";
    end else begin
      tag = mRun && start ? "R10" : "R4";
      mRun = 1'b1;
      ns = nsOf(mCar);
      cs = (mCar / 4) % 4;
      hit = (cs == 0) ? 1'b1 : condFlags[cs-1];
      if (ns == 1 || (ns == 2 && hit)) begin
        mCar = 0; mUpc = 1; tag = {tag, (ns == 1) ? " R5 R8" : " R6 R8"};
      end else if (ns == 3) begin
        mCar = opcode * 4; mUpc = (mCar + 1) % 64; tag = {tag, " R7 R8"};
      end else begin
        mCar = mUpc; mUpc = (mUpc + 1) % 64;
        tag = {tag, (ns == 2) ? " R6 R9" : " R9"};
      end
    end
  endtask

  task automatic cycle();
    string tag;
    modelStep(tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " addr"}, int'(curAddr), mCar);
    check("R3 ctrl", int'(ctrlField), int'(expCtrl(mCar)));
  endtask

  initial begin
    int seedSink;
    seedSink = $urandom(32'h5EC0_0017);
    @(negedge clk);
    rst = 1'b1;
    cycle();               // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      opcode = 4'(i + 7);  // R2: idle ignores opcode and flags
      condFlags = 3'(i);
      cycle();
    end
    start = 1'b1;          // leaves idle: 0 -> 1
    cycle();
    start = 1'b0;
    opcode = 4'd4;         // R7 dispatch to 16, then R6 constant-true at 17
    cycle();
    cycle();
    cycle();
    opcode = 4'd9;         // 0 -> 1 -> map 36; 37 uses condFlags[0]
    condFlags = 3'b000;
    cycle();
    cycle();
    cycle();
    cycle();               // R6 not taken -> 38
    start = 1'b1;          // R10: start while running is ignored
    cycle();
    start = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      rst = ($urandom_range(0, 79) == 0);
      start = ($urandom_range(0, 7) == 0);
      opcode = 4'($urandom());
      condFlags = 3'($urandom());
      cycle();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule